// File: doc/BRIEF.md
# Sound Generator Register Interface

This block is the processor-facing register front end of a three-voice programmable sound generator. A small four-byte I/O window sits on the bus. Address bit 1 decides whether an access reaches the index port or the data port. The index port holds a full 8-bit register number. The data port then reads or writes one of sixteen 8-bit registers, provided that index names one of them.

Several rules apply to writes. A write to an odd offset is a mirror of the even port beside it. Such a write only counts when the bus transfer is a single byte, because a wider transfer also writes the even port. Stored values lose the bits that each register does not implement. Any index of sixteen or more blocks the data port entirely.

Every accepted access raises a wait request for one cycle. Downstream tone, noise, envelope and port logic sees the whole register file in parallel. For the fourteen sound-related registers it also receives a one-cycle update pulse that carries the register number and the stored value.

Top module: `snd_regif`

## Requirements
- R1: After synchronous reset the index latch and all sixteen registers are zero, and rdata, wait_req and upd_valid are 0.
- R2: The index latch stores all 8 written bits. A data access reaches register N only when the index equals N exactly. Index 0x13 does not reach register 3.
- R3: While the index is 16 or more, a data write changes no register and gives no update pulse, and a data read at offset 0 returns 0xFF.
- R4: offset[1]=0 selects the index port and offset[1]=1 selects the data port. A byte write at offset 1 sets the index, and a byte write at offset 3 writes the data register.
- R5: A read at offset 1, 2 or 3 returns 0xFF whatever the index and register contents are. A read at offset 0 with a valid index returns that register.
- R6: A write at an odd offset with size word (1) or long (2) is ignored. The index and the registers are unchanged, and wait_req stays 0 in the following cycle. Size byte is encoded 0.
- R7: Every accepted access (each read, each even-offset write, each byte-sized odd-offset write) sets wait_req to 1 in the next cycle only. An idle cycle gives 0.
- R8: Writes to registers 1, 3, 5 and 13 keep bits 3:0 and store 0 in bits 7:4.
- R9: Writes to registers 6, 8, 9 and 10 keep bits 4:0 and store 0 in bits 7:5. All other registers keep all 8 bits.
- R10: A data write to register 0 to 13 gives upd_valid=1 for one cycle, in the cycle after the write, with upd_index set to the register number and upd_value set to the masked value. Writes to registers 14 and 15 give no pulse.
- R11: regs_flat[8*i+7:8*i] shows register i, updated in the cycle after the write. rdata is updated in the cycle after a read and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Access strobe for the window, one cycle per access |
| rnw | input | 1 | 1 = read, 0 = write |
| offset | input | 2 | Byte offset within the window |
| size | input | 2 | Transfer size: 0 byte, 1 word, 2 long |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| wait_req | output | 1 | One-cycle wait request after an accepted access |
| regs_flat | output | 128 | All sixteen registers, register i at bits 8*i+7:8*i |
| upd_valid | output | 1 | Sound register update pulse |
| upd_index | output | 4 | Number of the updated register |
| upd_value | output | 8 | Masked value written |

## Verification
A corrupted index latch appears at once on the next offset-0 read. It returns the wrong register, or returns 0xFF when it should not, or real data where 0xFF is expected. It also appears on the next data write, which lands in the wrong slice of regs_flat one cycle later. A wrong mask or a wrong acceptance decision shows in the cycle after the write, in regs_flat, in upd_value or in wait_req. The bench therefore compares every port in every cycle against a reference model, so a fault is caught on the first cycle it can be seen.

// File: rtl/snd_regif_pkg.sv
package snd_regif_pkg;

    localparam int DW     = 8;
    localparam int NREG   = 16;
    localparam int NSOUND = 14;
    localparam int IDXW   = $clog2(NREG);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_IDX_WR = 2'd1,
        OP_DAT_WR = 2'd2,
        OP_READ   = 2'd3
    } bus_op_e;

    typedef struct packed {
        bus_op_e         op;
        logic            accept;
        logic            rd_live;
        logic [DW-1:0]   data;
    } bus_cmd_t;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] index;
        logic [DW-1:0]   value;
    } upd_t;

    // Implemented-bit mask per register number
    function automatic logic [DW-1:0] impl_mask(input logic [IDXW-1:0] idx);
        logic [DW-1:0] m;
        case (idx)
            4'd1, 4'd3, 4'd5, 4'd13: m = 8'h0F;
            4'd6, 4'd8, 4'd9, 4'd10: m = 8'h1F;
            default:                 m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/snd_bus_decode.sv
module snd_bus_decode
    import snd_regif_pkg::*;
(
    input  logic          cs,
    input  logic          rnw,
    input  logic [1:0]    offset,
    input  logic [1:0]    size,
    input  logic [DW-1:0] wdata,
    output bus_cmd_t      cmd
);
    logic mirror;
    logic narrow;

    always_comb begin
        mirror      = offset[0];
        narrow      = (acc_size_e'(size) == SZ_BYTE);
        cmd.accept  = cs && (rnw || !mirror || narrow);
        cmd.rd_live = (offset == 2'd0);
        cmd.data    = wdata;
        if (!cmd.accept)
            cmd.op = OP_NONE;
        else if (rnw)
            cmd.op = OP_READ;
        else if (offset[1])
            cmd.op = OP_DAT_WR;
        else
            cmd.op = OP_IDX_WR;
    end
endmodule

// File: rtl/snd_sel_latch.sv
module snd_sel_latch
    import snd_regif_pkg::*;
#(
    parameter int SW = DW,
    parameter int NR = NREG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [SW-1:0]           din,
    output logic [SW-1:0]           sel_q,
    output logic                    sel_ok,
    output logic [$clog2(NR)-1:0]   sel_idx
);
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (load)
            sel_q <= din;
    end

    always_comb begin
        sel_ok  = (int'(sel_q) < NR);
        sel_idx = sel_q[$clog2(NR)-1:0];
    end
endmodule

// File: rtl/snd_reg_file.sv
module snd_reg_file
    import snd_regif_pkg::*;
#(
    parameter int NR = NREG,
    parameter int NS = NSOUND
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [DW-1:0]         wr_data,
    input  logic [IDXW-1:0]       rd_idx,
    output logic [DW-1:0]         rd_word,
    output logic [NR*DW-1:0]      flat,
    output upd_t                  upd
);
    logic [DW-1:0] store [NR];
    logic [DW-1:0] masked;

    assign masked = wr_data & impl_mask(wr_idx);

    for (genvar i = 0; i < NR; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                store[i] <= '0;
            else if (wr_en && (wr_idx == IDXW'(i)))
                store[i] <= masked;
        end
        assign flat[i*DW +: DW] = store[i];
    end

    assign rd_word = store[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            upd <= '0;
        end else begin
            upd.valid <= wr_en && (int'(wr_idx) < NS);
            upd.index <= wr_idx;
            upd.value <= masked;
        end
    end

    AST_UPD_MASKED: assert property (@(posedge clk) disable iff (rst)
        upd.valid |-> ((upd.value & ~impl_mask(upd.index)) == '0)); // R8

    AST_UPD_SOUND_ONLY: assert property (@(posedge clk) disable iff (rst)
        upd.valid |-> (int'(upd.index) < NS)); // R10
endmodule

// File: rtl/snd_regif.sv
module snd_regif
    import snd_regif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs,
    input  logic                 rnw,
    input  logic [1:0]           offset,
    input  logic [1:0]           size,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 wait_req,
    output logic [NREG*DW-1:0]   regs_flat,
    output logic                 upd_valid,
    output logic [IDXW-1:0]      upd_index,
    output logic [DW-1:0]        upd_value
);
    bus_cmd_t        cmd;
    logic [DW-1:0]   sel_q;
    logic            sel_ok;
    logic [IDXW-1:0] sel_idx;
    logic [DW-1:0]   rd_word;
    upd_t            upd;

    snd_bus_decode u_dec (
        .cs(cs), .rnw(rnw), .offset(offset), .size(size),
        .wdata(wdata), .cmd(cmd)
    );

    snd_sel_latch #(.SW(DW), .NR(NREG)) u_sel (
        .clk(clk), .rst(rst),
        .load(cmd.op == OP_IDX_WR), .din(cmd.data),
        .sel_q(sel_q), .sel_ok(sel_ok), .sel_idx(sel_idx)
    );

    snd_reg_file #(.NR(NREG), .NS(NSOUND)) u_rf (
        .clk(clk), .rst(rst),
        .wr_en((cmd.op == OP_DAT_WR) && sel_ok),
        .wr_idx(sel_idx), .wr_data(cmd.data),
        .rd_idx(sel_idx), .rd_word(rd_word),
        .flat(regs_flat), .upd(upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            wait_req <= 1'b0;
        end else begin
            wait_req <= cmd.accept;
            if (cmd.op == OP_READ)
                rdata <= (cmd.rd_live && sel_ok) ? rd_word : '1;
        end
    end

    assign upd_valid = upd.valid;
    assign upd_index = upd.index;
    assign upd_value = upd.value;

    AST_MIRROR_WIDE_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (cs && !rnw && offset[0] && size != 2'd0) |=> !wait_req); // R6

    AST_ODD_READ_FF: assert property (@(posedge clk) disable iff (rst)
        (cs && rnw && offset != 2'd0) |=> (rdata == 8'hFF)); // R5

    AST_BAD_SEL_READ_FF: assert property (@(posedge clk) disable iff (rst)
        (cs && rnw && offset == 2'd0 && sel_q >= 8'd16) |=> (rdata == 8'hFF)); // R3

    AST_BAD_SEL_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        (cs && !rnw && offset[1] && sel_q >= 8'd16) |=> !upd_valid); // R3

    AST_READ_WAITS: assert property (@(posedge clk) disable iff (rst)
        (cs && rnw) |=> wait_req); // R7
endmodule

// File: tb/snd_regif_tb_top.sv
module snd_regif_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs = 1'b0, rnw = 1'b0;
    logic [1:0]   offset = '0, size = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         wait_req;
    logic [127:0] regs_flat;
    logic         upd_valid;
    logic [3:0]   upd_index;
    logic [7:0]   upd_value;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        bit           chk_rd;
        logic [7:0]   rd;
        bit           wt;
        bit           uv;
        logic [3:0]   ui;
        logic [7:0]   uval;
        logic [127:0] regs;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] sel_m = 8'h00;
    logic [7:0] regs_m [16];

    always #4 clk = ~clk;

    snd_regif dut_i (
        .clk(clk), .rst(rst), .cs(cs), .rnw(rnw), .offset(offset),
        .size(size), .wdata(wdata), .rdata(rdata), .wait_req(wait_req),
        .regs_flat(regs_flat), .upd_valid(upd_valid),
        .upd_index(upd_index), .upd_value(upd_value)
    );

    function automatic logic [7:0] keep_bits(input int r);
        if (r == 1 || r == 3 || r == 5 || r == 13) return 8'h0F;   // R8
        if (r == 6 || r == 8 || r == 9 || r == 10) return 8'h1F;   // R9
        return 8'hFF;
    endfunction

    function automatic logic [127:0] pack_model();
        logic [127:0] p;
        for (int i = 0; i < 16; i++) p[i*8 +: 8] = regs_m[i];
        return p;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one bus cycle, pushes the expected result
    task automatic access(input bit rd, input bit [1:0] off, input bit [1:0] sz,
                          input bit [7:0] d, input string tag);
        exp_t e;
        bit acc;
        @(negedge clk);
        cs = 1'b1; rnw = rd; offset = off; size = sz; wdata = d;
        acc = rd || !off[0] || (sz == 2'd0);
        e.wt = acc; e.chk_rd = rd; e.uv = 0; e.ui = '0; e.uval = '0; e.rd = '0;
        if (rd) begin
            e.rd = (off == 2'd0 && sel_m < 8'd16) ? regs_m[sel_m[3:0]] : 8'hFF;
        end else if (acc) begin
            if (!off[1]) begin
                sel_m = d;
            end else if (sel_m < 8'd16) begin
                regs_m[sel_m[3:0]] = d & keep_bits(int'(sel_m));
                if (sel_m < 8'd14) begin
                    e.uv = 1; e.ui = sel_m[3:0]; e.uval = regs_m[sel_m[3:0]];
                end
            end
        end
        e.regs = pack_model();
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            @(negedge clk);
            cs = 1'b0;
            e.wt = 0; e.chk_rd = 0; e.uv = 0; e.ui = '0; e.uval = '0; e.rd = '0;
            e.regs = pack_model();
            e.tag = "R7 idle";
            exp_q.push_back(e);
        end
    endtask

    // Monitor: compares one expected item per cycle after the edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " R7 wait_req"}, 128'(wait_req), 128'(e.wt));
            chk({e.tag, " R10 upd_valid"}, 128'(upd_valid), 128'(e.uv));
            if (e.uv) begin
                chk({e.tag, " R10 upd_index"}, 128'(upd_index), 128'(e.ui));
                chk({e.tag, " R10 upd_value"}, 128'(upd_value), 128'(e.uval));
            end
            if (e.chk_rd) chk({e.tag, " R11 rdata"}, 128'(rdata), 128'(e.rd));
            chk({e.tag, " R11 regs_flat"}, regs_flat, e.regs);
        end
    end

    initial begin
        #(200000 * 8);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs_m[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset rdata", 128'(rdata), 128'h0);
        chk("R1 reset wait_req", 128'(wait_req), 128'h0);
        chk("R1 reset upd_valid", 128'(upd_valid), 128'h0);
        chk("R1 reset regs", regs_flat, 128'h0);
        access(1, 2'd0, 2'd0, 8'h00, "R1 read reg0 after reset");

        // R8: coarse register mask
        access(0, 2'd0, 2'd0, 8'h01, "R8 select 1");
        access(0, 2'd2, 2'd0, 8'hFF, "R8 write reg1");
        access(1, 2'd0, 2'd0, 8'h00, "R8 read reg1");

        // R9/R10: fill all sixteen with word-sized even-offset writes
        for (int r = 0; r < 16; r++) begin
            access(0, 2'd0, 2'd1, 8'(r), "R9 select");
            access(0, 2'd2, 2'd1, 8'hE5 ^ 8'(r * 17), "R9 R10 write");
        end
        idle(2);
        for (int r = 0; r < 16; r++) begin
            access(0, 2'd0, 2'd0, 8'(r), "R5 select");
            access(1, 2'd0, 2'd0, 8'h00, "R5 read offset0");
        end

        // R4: aliasing via byte writes at odd offsets
        access(0, 2'd1, 2'd0, 8'h05, "R4 select via offset1");
        access(0, 2'd3, 2'd0, 8'h3C, "R4 write via offset3");
        access(1, 2'd0, 2'd0, 8'h00, "R4 read reg5");

        // R6: wide odd-offset writes ignored
        access(0, 2'd1, 2'd1, 8'h02, "R6 word at offset1");
        access(0, 2'd3, 2'd2, 8'hEE, "R6 long at offset3");
        access(0, 2'd3, 2'd1, 8'h11, "R6 word at offset3");
        access(1, 2'd0, 2'd0, 8'h00, "R6 read reg5 unchanged");

        // R5: reads at other offsets
        access(1, 2'd1, 2'd0, 8'h00, "R5 read offset1");
        access(1, 2'd2, 2'd1, 8'h00, "R5 read offset2");
        access(1, 2'd3, 2'd2, 8'h00, "R5 read offset3");

        // R2/R3: full-width index, out-of-range index
        access(0, 2'd0, 2'd0, 8'h13, "R2 select 0x13");
        access(1, 2'd0, 2'd0, 8'h00, "R3 read bad index");
        access(0, 2'd2, 2'd0, 8'h77, "R3 write bad index");
        access(0, 2'd0, 2'd0, 8'h83, "R2 select 0x83");
        access(0, 2'd3, 2'd0, 8'h55, "R3 byte write bad index");
        access(1, 2'd0, 2'd0, 8'h00, "R3 read bad index 0x83");
        access(0, 2'd0, 2'd0, 8'h03, "R2 select 3");
        access(1, 2'd0, 2'd0, 8'h00, "R2 read reg3");

        // R10: no pulse for registers 14 and 15
        access(0, 2'd0, 2'd0, 8'h0E, "R10 select 14");
        access(0, 2'd2, 2'd0, 8'hA7, "R10 write reg14");
        access(0, 2'd0, 2'd0, 8'h0F, "R10 select 15");
        access(0, 2'd2, 2'd0, 8'h5B, "R10 write reg15");
        access(1, 2'd0, 2'd0, 8'h00, "R11 read reg15");
        idle(1);
        access(0, 2'd0, 2'd0, 8'h0D, "R8 select 13");
        access(0, 2'd2, 2'd0, 8'hF9, "R8 write reg13");
        idle(3);
        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule